// File: doc/BRIEF.md
# Integer ALU with compare and shifts

A purely combinational integer unit for a small load/store datapath. Two operands, a shift count and a four-bit operation code go in; a result word and a zero flag come out in the same cycle. The zero flag is meant for equality branches: subtract two registers and branch when the flag is high.

The unit covers wrapping add and subtract, three bitwise operations, signed and unsigned less-than tests, zero-filling shifts in both directions, and placement of a half-width constant in the upper half of the word. There is no separate invert operation. Inverting is done by NOR against a zero operand. Operand routing, immediate extension, decode and the register file all sit outside the block.

Top module: `int_alu`

## Requirements
- R1: Code 0 (add) gives a_i + b_i modulo 2^WIDTH, and carry-out is discarded.
- R2: Code 1 (subtract) gives a_i - b_i in two's complement modulo 2^WIDTH, with no overflow signalling.
- R3: Code 2 gives the bitwise AND of a_i and b_i. Code 3 gives their bitwise OR.
- R4: Code 4 gives the bitwise inverse of (a_i OR b_i). With b_i zero this is the bitwise NOT of a_i.
- R5: Code 5 gives 1 when a_i < b_i as signed two's-complement values and 0 otherwise, zero-extended to full width.
- R6: Code 6 gives 1 when a_i < b_i as unsigned values and 0 otherwise. For a_i = all ones and b_i = 1, code 5 gives 1 and code 6 gives 0.
- R7: Code 7 shifts b_i left by shamt_i and fills the vacated low bits with zeros.
- R8: Code 8 shifts b_i right by shamt_i and fills the vacated high bits with zeros. The sign bit is not replicated.
- R9: Code 9 places b_i[WIDTH/2-1:0] in the upper half of the result and clears the lower half.
- R10: Codes 10 to 15 give a zero result.
- R11: zero_o is 1 exactly when result_o is all zeros. This includes the unused codes.
- R12: The outputs follow the inputs with no clock or register on the path, so they are valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand; the shifted value and the source of the constant |
| shamt_i | input | $clog2(WIDTH) | Shift count |
| op_i | input | 4 | Operation code |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The block holds no state, so any fault appears on result_o or zero_o at once, in the same cycle as the operand that triggers it. A defective stage in the shifter shows only for counts that have that bit of shamt_i set. A wrong sign rule in the comparator shows only when the two operands have different top bits. For this reason the directed vectors pair operands of opposite sign and cover every single-bit shift count. The reference model then checks every operation code against pseudo-random operands on every clock.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SLTU = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_LUI  = 4'd9
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum   = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};
    sum_o = sum;
    // Undo the operation: proves wraparound for add (R1) and sub (R2)
    if (sub_i) p_sub_inverse_r2: assert (sum + b_i == a_i);
    else       p_add_inverse_r1: assert (sum - b_i == a_i);
  end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             lt_o,
  output logic             ltu_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] diff;
  logic           lt;
  logic           ltu;

  always_comb begin
    diff  = {1'b0, a_i} - {1'b0, b_i};
    ltu   = diff[WIDTH];
    // Differing signs: the negative operand is smaller
    lt    = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : diff[MSB];
    lt_o  = lt;
    ltu_o = ltu;
    if (a_i == b_i) p_equal_not_less_r5: assert (!lt && !ltu);
    if (a_i[MSB] == b_i[MSB]) p_same_sign_agree_r6: assert (lt == ltu);
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic             right_i,
  output logic [WIDTH-1:0] out_o
);
  logic [WIDTH-1:0] stage [0:SHW];
  logic [WIDTH-1:0] val_rev;
  logic [WIDTH-1:0] out_rev;
  logic [WIDTH-1:0] out;
  logic [WIDTH-1:0] low_mask;

  // One left shifter; right shifts reverse bit order on the way in and out
  always_comb begin
    for (int i = 0; i < WIDTH; i++) val_rev[i] = val_i[WIDTH-1-i];
  end

  assign stage[0] = right_i ? val_rev : val_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stage[k+1] = shamt_i[k] ? {stage[k][WIDTH-1-D:0], {D{1'b0}}} : stage[k];
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) out_rev[i] = stage[SHW][WIDTH-1-i];
    out      = right_i ? out_rev : stage[SHW];
    out_o    = out;
    low_mask = (WIDTH'(1) << shamt_i) - WIDTH'(1);
    if (shamt_i == '0) p_zero_shift_passes_r7: assert (out == val_i);
    if (!right_i) p_left_zero_fill_r7: assert ((out & low_mask) == '0);
    if (right_i && shamt_i != '0)
      p_right_zero_fill_r8: assert ((out >> (WIDTH - int'(shamt_i))) == '0);
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH),
  localparam int HALF = WIDTH / 2
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] sum;
  logic             lt;
  logic             ltu;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] res;

  alu_addsub #(.WIDTH(WIDTH)) i_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op_i == OP_SUB),
    .sum_o (sum)
  );

  alu_cmp #(.WIDTH(WIDTH)) i_cmp (
    .a_i   (a_i),
    .b_i   (b_i),
    .lt_o  (lt),
    .ltu_o (ltu)
  );

  alu_shift #(.WIDTH(WIDTH)) i_shift (
    .val_i   (b_i),
    .shamt_i (shamt_i),
    .right_i (op_i == OP_SRL),
    .out_o   (shifted)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB: res = sum;
      OP_AND:         res = a_i & b_i;
      OP_OR:          res = a_i | b_i;
      OP_NOR:         res = ~(a_i | b_i);
      OP_SLT:         res = {{(WIDTH-1){1'b0}}, lt};
      OP_SLTU:        res = {{(WIDTH-1){1'b0}}, ltu};
      OP_SLL, OP_SRL: res = shifted;
      OP_LUI:         res = {b_i[HALF-1:0], {HALF{1'b0}}};
      default:        res = '0;
    endcase
    result_o = res;
    zero_o   = ~|res;
    if (op_i == OP_NOR && b_i == '0) p_nor_as_not_r4: assert ((res ^ a_i) == '1);
    if (op_i == OP_LUI) p_lui_low_clear_r9: assert (res[HALF-1:0] == '0);
  end
endmodule

// File: tb/test_int_alu.sv
module test_int_alu;
  localparam int W = 32;
  localparam int SHW = 5;

  logic [W-1:0]   a, b;
  logic [SHW-1:0] sh;
  logic [3:0]     op;
  logic [W-1:0]   res;
  logic           zf;
  logic           clk = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  int_alu #(.WIDTH(W)) i_int_alu (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op), .result_o(res), .zero_o(zf)
  );

  function automatic logic [W-1:0] model(input logic [3:0] o, input logic [W-1:0] x,
                                         input logic [W-1:0] y, input logic [SHW-1:0] s);
    case (o)
      4'd0: return x + y;
      4'd1: return x - y;
      4'd2: return x & y;
      4'd3: return x | y;
      4'd4: return ~(x | y);
      4'd5: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd6: return (x < y) ? 32'd1 : 32'd0;
      4'd7: return y << s;
      4'd8: return y >> s;
      4'd9: return {y[15:0], 16'h0000};
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk_val(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Inputs change at negedge; outputs sampled 1 ns later in the same cycle (R12)
  task automatic apply(input logic [3:0] o, input logic [W-1:0] x,
                       input logic [W-1:0] y, input logic [SHW-1:0] s);
    logic [W-1:0] e;
    @(negedge clk);
    op = o; a = x; b = y; sh = s;
    #1;
    e = model(o, x, y, s);
    chk_val(req_of(o), res, e);
    chk_val("R11", {31'd0, zf}, {31'd0, e == '0});
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    op = 4'd15; a = '0; b = '0; sh = '0;
    #1;
    // Idle unused code: zero result, zero flag high (R10, R11)
    chk_val("R10", res, '0);
    chk_val("R11", {31'd0, zf}, 32'd1);
    // R1 wrap, R2 wrap
    apply(4'd0, 32'hFFFF_FFFF, 32'd1, 0);
    apply(4'd0, 32'h7FFF_FFFF, 32'd1, 0);
    apply(4'd1, 32'd0, 32'd1, 0);
    apply(4'd1, 32'h1234_5678, 32'h1234_5678, 0);
    apply(4'd1, 32'h8000_0000, 32'd1, 0);
    // R3
    apply(4'd2, 32'hF0F0_1234, 32'h0FF0_FF00, 0);
    apply(4'd3, 32'hF000_0001, 32'h0000_0F10, 0);
    // R4 NOT via zero
    apply(4'd4, 32'h0000_0000, 32'h0, 0);
    apply(4'd4, 32'hA5A5_0F0F, 32'h0, 0);
    apply(4'd4, 32'hFFFF_FFFF, 32'h0, 0);
    // R5/R6 sign cases, example from R6
    apply(4'd5, 32'hFFFF_FFFF, 32'd1, 0);
    apply(4'd6, 32'hFFFF_FFFF, 32'd1, 0);
    apply(4'd5, 32'd1, 32'hFFFF_FFFF, 0);
    apply(4'd6, 32'd1, 32'hFFFF_FFFF, 0);
    apply(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 0);
    apply(4'd6, 32'h8000_0000, 32'h7FFF_FFFF, 0);
    apply(4'd5, 32'd7, 32'd7, 0);
    apply(4'd6, 32'd7, 32'd7, 0);
    // R7/R8 every single-bit count plus extremes
    for (int k = 0; k < SHW; k++) begin
      apply(4'd7, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 5'(1 << k));
      apply(4'd8, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 5'(1 << k));
    end
    apply(4'd7, 0, 32'h8000_0001, 5'd31);
    apply(4'd8, 0, 32'h8000_0001, 5'd31);
    apply(4'd8, 0, 32'h8000_0000, 5'd0);
    // R9
    apply(4'd9, 32'hFFFF_FFFF, 32'hABCD_1234, 0);
    apply(4'd9, 0, 32'hFFFF_0000, 0);
    // R10 all unused codes with nonzero operands
    for (int c = 10; c < 16; c++) apply(4'(c), 32'hFFFF_FFFF, 32'h1357_9BDF, 5'd3);
    // Randomised sweep over all codes
    for (int n = 0; n < 3000; n++)
      apply(4'($urandom_range(0, 15)), $urandom(), $urandom(), 5'($urandom_range(0, 31)));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule